// File: doc/BRIEF.md
# Masked interrupt flag register

This block gathers five one-cycle event pulses into sticky flag bits: timer A underflow, timer B underflow, time-of-day alarm, serial byte complete and flag-pin edge. A mask register chooses which flags may pull the active-low interrupt line. The host reaches the block through one register address on a bus whose cycles end with a completion strobe. That strobe marks the falling edge of the bus clock phase.

A read returns the flags and a summary bit. The flags clear only when a read cycle at this address actually completes. An access that is abandoned before the strobe changes nothing. An event that arrives in the cycle of a completed read shows up in that read's data and is then discarded. The next read never reports it. A write changes the mask: bit 7 of the data chooses between setting and clearing the mask bits named by ones in the low five bits.

Top module: `irq_flag_reg`

## Requirements
- R1: Flags use these bit positions: 0 timer A, 1 timer B, 2 alarm, 3 serial byte, 4 flag pin. A pulse on an event input sets its flag whatever the mask holds, and the flag stays set until it is cleared.
- R2: Read data bit 7 is 1 exactly when some visible flag is also enabled in the mask. Bits 6 and 5 read 0. Bits 4..0 show the latched flags ORed with the events of the current cycle.
- R3: A completed write with data bit 7 = 1 sets the mask bits marked by ones in data bits 4..0. With bit 7 = 0 it clears them. Other mask bits are kept, so 0x83 enables both timers and 0x7F disables all sources.
- R4: `irq_n` is 0 while any latched flag has its mask bit set, and 1 otherwise.
- R5: A read of the register address that completes (select, read and end strobe all high) clears all flags at that clock edge, which releases `irq_n`.
- R6: A read held without the end strobe returns data but clears nothing.
- R7: An event pulsed in the cycle of a completed read appears in that read's data and is lost afterwards.
- R8: A completed access to any other address leaves the flags and the mask unchanged.
- R9: A synchronous reset clears all flags and mask bits and drives `irq_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Chip selected |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_end | input | 1 | Access completes this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: summary bit and flags |
| bus_ev | input | 5 | Event pulses, one bit per source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench goes after the read-versus-event race. If a design latched the colliding event, it would be reported a second time by the following read. If a design hid the event from the colliding read, it would never be reported at all. Abandoned reads come next: a design that cleared on select alone would lose flags during an address scan. Masked events come last: a design that gated the latch with the mask would return an empty read after a masked alarm. The bench also checks that a write with bit 7 clear leaves unnamed mask bits alone, and that accesses at another address are ignored.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int NSRC = 5,
  parameter int AW = 4,
  parameter logic [AW-1:0] REG_ADDR = 'hD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_end,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [NSRC-1:0] bus_ev,
  output logic          irq_n
);
  localparam int PAD = 7 - NSRC;

  logic [NSRC-1:0] flag_q, mask_q, vis;
  logic hit, rd_done, wr_done;

  assign hit     = bus_sel && (bus_addr == REG_ADDR);
  assign rd_done = hit && bus_rd && bus_end;
  assign wr_done = hit && !bus_rd && bus_end;
  assign vis     = flag_q | bus_ev;

  assign bus_rdata = {|(vis & mask_q), {PAD{1'b0}}, vis};
  assign irq_n     = ~|(flag_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else if (rd_done) flag_q <= '0;
    else flag_q <= vis;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr_done) begin
      if (bus_wdata[7]) mask_q <= mask_q | bus_wdata[NSRC-1:0];
      else mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
    end
  end
endmodule

module irq_flag_reg_chk #(
  parameter int NSRC = 5,
  parameter int AW = 4,
  parameter logic [AW-1:0] REG_ADDR = 'hD
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_end,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [NSRC-1:0] bus_ev,
  input logic          irq_n
);
  logic rd_done, scan, wr_done;
  assign rd_done = bus_sel && bus_addr == REG_ADDR && bus_rd && bus_end;
  assign scan    = bus_sel && bus_addr == REG_ADDR && bus_rd && !bus_end;
  assign wr_done = bus_sel && bus_addr == REG_ADDR && !bus_rd && bus_end;

  a_r1_event_latched: assert property (@(posedge clk) disable iff (rst)
    (|bus_ev && !rd_done) |=> ((bus_rdata[NSRC-1:0] & $past(bus_ev)) == $past(bus_ev)));
  a_r2_summary_bit: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> bus_rdata[7]);
  a_r3_disable_all: assert property (@(posedge clk) disable iff (rst)
    (wr_done && bus_wdata == 8'h7F) |=> irq_n);
  a_r5_read_releases: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> irq_n);
  a_r6_scan_keeps: assert property (@(posedge clk) disable iff (rst)
    (scan && !irq_n) |=> !irq_n);
  a_r7_race_lost: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> ((bus_rdata[NSRC-1:0] & ~bus_ev) == '0));
  a_r9_reset_release: assert property (@(posedge clk)
    rst |=> irq_n);
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.NSRC(NSRC), .AW(AW), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_rd = 1, bus_end = 0;
  logic [3:0] bus_addr = 4'hD;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [4:0] bus_ev = 0;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_flag_reg u_dut (.clk, .rst, .bus_sel, .bus_addr, .bus_rd, .bus_end,
                      .bus_wdata, .bus_rdata, .bus_ev, .irq_n);

  // {req[3:0], ev[4:0], op[1:0], wdata[7:0], exp_rdata[7:0], exp_irq_n}
  // op: 0 idle, 1 completed read, 2 completed write, 3 read without end strobe
  localparam logic [27:0] VEC [16] = '{
    {4'd3, 5'h00, 2'd2, 8'h83, 8'h00, 1'b1},  // R3 enable timers
    {4'd4, 5'h01, 2'd0, 8'h00, 8'h00, 1'b0},  // R4 timer A
    {4'd5, 5'h00, 2'd1, 8'h00, 8'h81, 1'b1},  // R5 read clears
    {4'd1, 5'h04, 2'd0, 8'h00, 8'h00, 1'b1},  // R1 masked alarm
    {4'd1, 5'h00, 2'd1, 8'h00, 8'h04, 1'b1},  // R1 R2 alarm latched, no summary
    {4'd6, 5'h02, 2'd3, 8'h00, 8'h82, 1'b0},  // R6 scan with timer B
    {4'd6, 5'h00, 2'd3, 8'h00, 8'h82, 1'b0},  // R6 still pending
    {4'd7, 5'h01, 2'd1, 8'h00, 8'h83, 1'b1},  // R7 race shown
    {4'd7, 5'h00, 2'd1, 8'h00, 8'h00, 1'b1},  // R7 race lost
    {4'd3, 5'h00, 2'd2, 8'h7F, 8'h00, 1'b1},  // R3 disable all
    {4'd4, 5'h08, 2'd0, 8'h00, 8'h00, 1'b1},  // R4 serial masked
    {4'd3, 5'h00, 2'd2, 8'h98, 8'h00, 1'b0},  // R3 set serial+flag
    {4'd3, 5'h00, 2'd2, 8'h08, 8'h00, 1'b1},  // R3 clear serial only
    {4'd4, 5'h10, 2'd0, 8'h00, 8'h00, 1'b0},  // R4 flag pin
    {4'd2, 5'h00, 2'd1, 8'h00, 8'h98, 1'b1},  // R2 summary with two flags
    {4'd2, 5'h00, 2'd1, 8'h00, 8'h00, 1'b1}   // R2 empty
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic sel, input logic [3:0] a, input logic rd,
                       input logic e, input logic [7:0] wd, input logic [4:0] ev);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_rd = rd; bus_end = e; bus_wdata = wd; bus_ev = ev;
    #2;
  endtask

  task automatic idle_after_edge();
    @(posedge clk); #2;
    bus_sel = 0; bus_end = 0; bus_ev = 0; bus_rd = 1;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R9 flags after reset", bus_rdata, 8'h00);
    @(negedge clk); rst = 0;

    foreach (VEC[i]) begin
      logic [27:0] v;
      logic [1:0] op;
      v = VEC[i];
      op = v[18:17];
      drive(op != 0, 4'hD, op != 2, op == 1 || op == 2, v[16:9], v[23:19]);
      if (op == 1 || op == 3)
        chk($sformatf("R%0d vector %0d rdata", v[27:24], i), bus_rdata, v[8:1]);
      idle_after_edge();
      chk($sformatf("R%0d vector %0d irq_n", v[27:24], i), {7'd0, irq_n}, {7'd0, v[0]});
    end

    // R8: accesses at another address change nothing
    drive(1, 4'hD, 0, 1, 8'h81, 0); idle_after_edge();
    drive(0, 4'hD, 1, 0, 0, 5'h01); idle_after_edge();
    drive(1, 4'hC, 1, 1, 0, 0); idle_after_edge();
    drive(1, 4'hE, 0, 1, 8'h01, 0); idle_after_edge();
    chk("R8 irq_n after foreign accesses", {7'd0, irq_n}, 8'h00);
    drive(1, 4'hD, 1, 0, 0, 0);
    chk("R8 flags after foreign accesses", bus_rdata, 8'h81);
    idle_after_edge();
    drive(0, 4'hD, 1, 1, 0, 0); idle_after_edge();
    chk("R8 unselected end strobe keeps irq", {7'd0, irq_n}, 8'h00);

    // R9: mid-run reset clears flags and mask
    drive(0, 4'hD, 1, 0, 0, 5'h1F); idle_after_edge();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    #2;
    chk("R9 irq_n after mid-run reset", {7'd0, irq_n}, 8'h01);
    chk("R9 flags after mid-run reset", bus_rdata, 8'h00);
    drive(0, 4'hD, 1, 0, 0, 5'h01); idle_after_edge();
    chk("R9 mask cleared by reset", {7'd0, irq_n}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule